// File: doc/BRIEF.md
# 32-pin general-purpose IO port controller

This block controls one port of 32 pads. A word-wide register bus programs each pin. A pin is either owned by the port itself, which drives a stored output value under a stored output enable, or handed to one of two on-chip peripherals (A or B) that supply their own value and enable. Per pin the port also holds a pull-up control, an input glitch filter enable and a multi-drive enable. With multi-drive, an enabled pin only pulls low and releases the line instead of driving high.

Every configuration field is changed only through a pair of write-one registers, one that sets bits and one that clears them, and each field has a read-only status word. Software therefore never has to read, modify and write a shared word. Pad inputs are brought into the clock domain by a two-flop synchronizer. They can optionally be filtered, and the resulting levels are readable as one word.

Top module: `pio_port`

Register offsets (word index on `bus_addr`): 0x00 IO on, 0x01 IO off, 0x02 IO status; 0x04 drive on, 0x05 drive off, 0x06 drive status; 0x08 filter on, 0x09 filter off, 0x0A filter status; 0x0C output set, 0x0D output clear, 0x0E output status, 0x0F pin level; 0x10 multi-drive on, 0x11 multi-drive off, 0x12 multi-drive status; 0x14 pull-up off, 0x15 pull-up on, 0x16 pull-up status; 0x18 pick A, 0x19 pick B, 0x1A pick status (1 = B). Bit i of every word belongs to pin i.

## Requirements
- R1: After reset, IO status reads 0xFFFFFFFF, and the drive, filter, multi-drive, output, pull-up and pick status words all read 0. `pad_oe` is 0 and `pad_pullup` is all ones.
- R2: Writing a word to an "on" register sets exactly the bits that are 1 in it, and writing to the matching "off" register clears exactly those bits. Bits written as 0 keep their value. This holds for IO, drive, filter, multi-drive and pull-up.
- R3: Output set (0x0C) sets, and output clear (0x0D) clears, only the bits written as 1 in the stored output word read at 0x0E. A write of 0 changes nothing.
- R4: For a pin with IO status 0, `pad_out` and `pad_oe` follow `pa_out`/`pa_oe` when its pick status bit is 0 and `pb_out`/`pb_oe` when it is 1. Pick A (0x18) clears and pick B (0x19) sets that bit.
- R5: For a pin with IO status 1 and multi-drive off, `pad_out` equals the stored output bit and `pad_oe` equals the drive status bit, whatever the peripherals present.
- R6: Pull-up status bit is 1 when that pin's pull-up is disabled and 0 when active; `pad_pullup` is its inverse.
- R7: With multi-drive on, `pad_out` is 0 and `pad_oe` is 1 only when the selected enable is 1 and the selected value is 0; a high value releases the pad.
- R8: With its filter off, a pin's bit in the pin level word (0x0F) shows a new `pad_in` level exactly two clock edges after the level is applied.
- R9: With its filter on, a new level shows exactly four edges after being applied if it stays put, and a pulse lasting one clock cycle never shows.
- R10: Writes to status and pin level words change nothing. Reads of write-only or unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pullup | output | 32 | Pad pull-up enable |
| pa_out | input | 32 | Peripheral A output value |
| pa_oe | input | 32 | Peripheral A output enable |
| pb_out | input | 32 | Peripheral B output value |
| pb_oe | input | 32 | Peripheral B output enable |

## Verification
The hardest situation to reach is a pulse lasting one clock cycle on a filtered pin. From the bus it cannot be told apart from no pulse at all, unless the latency of an accepted level is also pinned down. The stimulus drives the pad at the falling edge, one cycle high and then low again, on a filtered and an unfiltered pin together. It samples the level word after every following edge, so the unfiltered pin shows the pulse and the filtered pin must never show it. A separate step holds a level on the filtered pin and confirms it appears on the fourth edge and not the third.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int unsigned PIO_AW = 5;

    typedef enum logic [PIO_AW-1:0] {
        REG_IO_ON   = 5'h00,
        REG_IO_OFF  = 5'h01,
        REG_IO_ST   = 5'h02,
        REG_OE_ON   = 5'h04,
        REG_OE_OFF  = 5'h05,
        REG_OE_ST   = 5'h06,
        REG_FLT_ON  = 5'h08,
        REG_FLT_OFF = 5'h09,
        REG_FLT_ST  = 5'h0A,
        REG_OUT_SET = 5'h0C,
        REG_OUT_CLR = 5'h0D,
        REG_OUT_ST  = 5'h0E,
        REG_PIN_ST  = 5'h0F,
        REG_MD_ON   = 5'h10,
        REG_MD_OFF  = 5'h11,
        REG_MD_ST   = 5'h12,
        REG_PU_OFF  = 5'h14,
        REG_PU_ON   = 5'h15,
        REG_PU_ST   = 5'h16,
        REG_SEL_A   = 5'h18,
        REG_SEL_B   = 5'h19,
        REG_SEL_ST  = 5'h1A
    } pio_reg_e;

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [PIO_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_lvl,
    output logic [NPINS-1:0]  io_en,
    output logic [NPINS-1:0]  oe_en,
    output logic [NPINS-1:0]  flt_en,
    output logic [NPINS-1:0]  md_en,
    output logic [NPINS-1:0]  pu_dis,
    output logic [NPINS-1:0]  odata,
    output logic [NPINS-1:0]  bsel
);

    typedef struct packed {
        logic [NPINS-1:0] io_en;
        logic [NPINS-1:0] oe_en;
        logic [NPINS-1:0] flt_en;
        logic [NPINS-1:0] md_en;
        logic [NPINS-1:0] pu_dis;
        logic [NPINS-1:0] odata;
        logic [NPINS-1:0] bsel;
    } cfg_t;

    localparam logic [NPINS-1:0] ALL1 = {NPINS{1'b1}};
    localparam logic [NPINS-1:0] ALL0 = {NPINS{1'b0}};
    localparam cfg_t CFG_RST = '{
        io_en:  ALL1,
        oe_en:  ALL0,
        flt_en: ALL0,
        md_en:  ALL0,
        pu_dis: ALL0,
        odata:  ALL0,
        bsel:   ALL0
    };

    cfg_t cfg_d, cfg_q;
    logic wr_hit, rd_hit;

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_hit) begin
            case (pio_reg_e'(bus_addr))
                REG_IO_ON:   cfg_d.io_en  = cfg_q.io_en  |  bus_wdata;
                REG_IO_OFF:  cfg_d.io_en  = cfg_q.io_en  & ~bus_wdata;
                REG_OE_ON:   cfg_d.oe_en  = cfg_q.oe_en  |  bus_wdata;
                REG_OE_OFF:  cfg_d.oe_en  = cfg_q.oe_en  & ~bus_wdata;
                REG_FLT_ON:  cfg_d.flt_en = cfg_q.flt_en |  bus_wdata;
                REG_FLT_OFF: cfg_d.flt_en = cfg_q.flt_en & ~bus_wdata;
                REG_OUT_SET: cfg_d.odata  = cfg_q.odata  |  bus_wdata;
                REG_OUT_CLR: cfg_d.odata  = cfg_q.odata  & ~bus_wdata;
                REG_MD_ON:   cfg_d.md_en  = cfg_q.md_en  |  bus_wdata;
                REG_MD_OFF:  cfg_d.md_en  = cfg_q.md_en  & ~bus_wdata;
                REG_PU_OFF:  cfg_d.pu_dis = cfg_q.pu_dis |  bus_wdata;
                REG_PU_ON:   cfg_d.pu_dis = cfg_q.pu_dis & ~bus_wdata;
                REG_SEL_A:   cfg_d.bsel   = cfg_q.bsel   & ~bus_wdata;
                REG_SEL_B:   cfg_d.bsel   = cfg_q.bsel   |  bus_wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            case (pio_reg_e'(bus_addr))
                REG_IO_ST:  bus_rdata = cfg_q.io_en;
                REG_OE_ST:  bus_rdata = cfg_q.oe_en;
                REG_FLT_ST: bus_rdata = cfg_q.flt_en;
                REG_OUT_ST: bus_rdata = cfg_q.odata;
                REG_PIN_ST: bus_rdata = pin_lvl;
                REG_MD_ST:  bus_rdata = cfg_q.md_en;
                REG_PU_ST:  bus_rdata = cfg_q.pu_dis;
                REG_SEL_ST: bus_rdata = cfg_q.bsel;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign io_en  = cfg_q.io_en;
    assign oe_en  = cfg_q.oe_en;
    assign flt_en = cfg_q.flt_en;
    assign md_en  = cfg_q.md_en;
    assign pu_dis = cfg_q.pu_dis;
    assign odata  = cfg_q.odata;
    assign bsel   = cfg_q.bsel;

endmodule

// File: rtl/pio_in_filt.sv
module pio_in_filt #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] flt_en,
    output logic [NPINS-1:0] pin_lvl
);

    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] sync;
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] held;
    } in_t;

    in_t in_d, in_q;
    logic [NPINS-1:0] agree;

    // A synchronized level that matched the one before it is stable for two cycles.
    assign agree = ~(in_q.sync ^ in_q.prev);

    always_comb begin
        in_d      = in_q;
        in_d.meta = pad_in;
        in_d.sync = in_q.meta;
        in_d.prev = in_q.sync;
        in_d.held = (in_q.held & ~agree) | (in_q.sync & agree);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    assign pin_lvl = (flt_en & in_q.held) | (~flt_en & in_q.sync);

endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS-1:0] io_en,
    input  logic [NPINS-1:0] oe_en,
    input  logic [NPINS-1:0] md_en,
    input  logic [NPINS-1:0] pu_dis,
    input  logic [NPINS-1:0] odata,
    input  logic [NPINS-1:0] bsel,
    input  logic [NPINS-1:0] pa_out,
    input  logic [NPINS-1:0] pa_oe,
    input  logic [NPINS-1:0] pb_out,
    input  logic [NPINS-1:0] pb_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pullup
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic src_val;
        logic src_oe;

        always_comb begin
            if (io_en[i]) begin
                src_val = odata[i];
                src_oe  = oe_en[i];
            end else if (bsel[i]) begin
                src_val = pb_out[i];
                src_oe  = pb_oe[i];
            end else begin
                src_val = pa_out[i];
                src_oe  = pa_oe[i];
            end
        end

        // Multi-drive: pull low only, release instead of driving high.
        assign pad_out[i]    = md_en[i] ? 1'b0 : src_val;
        assign pad_oe[i]     = md_en[i] ? (src_oe & ~src_val) : src_oe;
        assign pad_pullup[i] = ~pu_dis[i];
    end

endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [PIO_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pullup,
    input  logic [NPINS-1:0]  pa_out,
    input  logic [NPINS-1:0]  pa_oe,
    input  logic [NPINS-1:0]  pb_out,
    input  logic [NPINS-1:0]  pb_oe
);

    logic [NPINS-1:0] io_en;
    logic [NPINS-1:0] oe_en;
    logic [NPINS-1:0] flt_en;
    logic [NPINS-1:0] md_en;
    logic [NPINS-1:0] pu_dis;
    logic [NPINS-1:0] odata;
    logic [NPINS-1:0] bsel;
    logic [NPINS-1:0] pin_lvl;

    pio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_lvl   (pin_lvl),
        .io_en     (io_en),
        .oe_en     (oe_en),
        .flt_en    (flt_en),
        .md_en     (md_en),
        .pu_dis    (pu_dis),
        .odata     (odata),
        .bsel      (bsel)
    );

    pio_in_filt #(.NPINS(NPINS)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .flt_en  (flt_en),
        .pin_lvl (pin_lvl)
    );

    pio_pad_mux #(.NPINS(NPINS)) u_mux (
        .io_en      (io_en),
        .oe_en      (oe_en),
        .md_en      (md_en),
        .pu_dis     (pu_dis),
        .odata      (odata),
        .bsel       (bsel),
        .pa_out     (pa_out),
        .pa_oe      (pa_oe),
        .pb_out     (pb_out),
        .pb_oe      (pb_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pullup (pad_pullup)
    );

endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [PIO_AW-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pb_out,
    input logic [NPINS-1:0]  io_en,
    input logic [NPINS-1:0]  oe_en,
    input logic [NPINS-1:0]  md_en,
    input logic [NPINS-1:0]  odata,
    input logic [NPINS-1:0]  bsel,
    input logic [NPINS-1:0]  flt_en,
    input logic [NPINS-1:0]  pin_lvl
);

    logic [1:0] live_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_cnt <= 2'd0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_OE_ON)
        |=> ((oe_en & $past(bus_wdata)) == $past(bus_wdata)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_OUT_CLR)
        |=> ((odata & $past(bus_wdata)) == '0));

    p_pick_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ pb_out) & ~io_en & ~md_en & bsel) == '0));

    p_no_drive_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & md_en) == '0));

    p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd3) |-> (((pin_lvl ^ $past(pad_in, 2)) & ~flt_en) == '0));

    p_status_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_IO_ST) |=> $stable(io_en));

endmodule

bind pio_port pio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pb_out    (pb_out),
    .io_en     (io_en),
    .oe_en     (oe_en),
    .md_en     (md_en),
    .odata     (odata),
    .bsel      (bsel),
    .flt_en    (flt_en),
    .pin_lvl   (pin_lvl)
);

// File: tb/pio_port_test.sv
module pio_port_test;
    import pio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pullup;
    logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;

    int n_chk = 0;
    int n_err = 0;

    pio_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pullup (pad_pullup),
        .pa_out     (pa_out),
        .pa_oe      (pa_oe),
        .pb_out     (pb_out),
        .pb_oe      (pb_oe)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic reg_peek(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_peek(a, d);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_rd(REG_IO_ST, v);  check("R1 io status", v, 32'hFFFF_FFFF);
        reg_rd(REG_OE_ST, v);  check("R1 drive status", v, 32'h0);
        reg_rd(REG_FLT_ST, v); check("R1 filter status", v, 32'h0);
        reg_rd(REG_MD_ST, v);  check("R1 multi-drive status", v, 32'h0);
        reg_rd(REG_OUT_ST, v); check("R1 output status", v, 32'h0);
        reg_rd(REG_PU_ST, v);  check("R1 pull-up status", v, 32'h0);
        reg_rd(REG_SEL_ST, v); check("R1 pick status", v, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_pullup", pad_pullup, 32'hFFFF_FFFF);
    endtask

    task automatic t_set_clear;
        logic [31:0] v;
        reg_wr(REG_OE_ON, 32'h0000_00F0);
        reg_rd(REG_OE_ST, v); check("R2 drive on", v, 32'h0000_00F0);
        reg_wr(REG_OE_ON, 32'h0000_0F00);
        reg_rd(REG_OE_ST, v); check("R2 drive on keeps others", v, 32'h0000_0FF0);
        reg_wr(REG_OE_OFF, 32'h0000_0030);
        reg_rd(REG_OE_ST, v); check("R2 drive off", v, 32'h0000_0FC0);
        reg_wr(REG_MD_ON, 32'h0000_0005);
        reg_wr(REG_MD_OFF, 32'h0000_0001);
        reg_rd(REG_MD_ST, v); check("R2 multi-drive on/off", v, 32'h0000_0004);
        reg_wr(REG_FLT_ON, 32'h8000_0001);
        reg_wr(REG_FLT_OFF, 32'h0000_0001);
        reg_rd(REG_FLT_ST, v); check("R2 filter on/off", v, 32'h8000_0000);
        reg_wr(REG_IO_OFF, 32'h0000_0003);
        reg_wr(REG_IO_ON, 32'h0000_0001);
        reg_rd(REG_IO_ST, v); check("R2 io on/off", v, 32'hFFFF_FFFD);
        reg_wr(REG_OE_OFF, '1);
        reg_wr(REG_MD_OFF, '1);
        reg_wr(REG_FLT_OFF, '1);
        reg_wr(REG_IO_ON, '1);
    endtask

    task automatic t_output;
        logic [31:0] v;
        reg_wr(REG_OUT_SET, 32'h0000_00A5);
        reg_rd(REG_OUT_ST, v); check("R3 output set", v, 32'h0000_00A5);
        reg_wr(REG_OUT_SET, 32'h0000_0100);
        reg_rd(REG_OUT_ST, v); check("R3 output set keeps others", v, 32'h0000_01A5);
        reg_wr(REG_OUT_CLR, 32'h0000_0005);
        reg_rd(REG_OUT_ST, v); check("R3 output clear", v, 32'h0000_01A0);
        reg_wr(REG_OUT_CLR, 32'h0);
        reg_rd(REG_OUT_ST, v); check("R3 clear of zero", v, 32'h0000_01A0);
        reg_wr(REG_OUT_CLR, '1);
    endtask

    task automatic t_io_drive;
        pa_out = '1; pa_oe = '1; pb_out = '1; pb_oe = '1;
        reg_wr(REG_OUT_SET, 32'h0000_00FF);
        reg_wr(REG_OE_ON, 32'h0000_0F0F);
        #1;
        check("R5 pad_out from stored data", pad_out, 32'h0000_00FF);
        check("R5 pad_oe from drive status", pad_oe, 32'h0000_0F0F);
        reg_wr(REG_OUT_CLR, '1);
        reg_wr(REG_OE_OFF, '1);
        pa_out = '0; pa_oe = '0; pb_out = '0; pb_oe = '0;
    endtask

    task automatic t_periph;
        logic [31:0] v;
        pa_out = 32'hAAAA_5555; pa_oe = 32'h0000_FFFF;
        pb_out = 32'h1234_56F8; pb_oe = 32'hFFFF_00C0;
        reg_wr(REG_IO_OFF, 32'h0000_00F0);
        reg_wr(REG_SEL_B, 32'h0000_00C0);
        reg_rd(REG_SEL_ST, v); check("R4 pick status B", v, 32'h0000_00C0);
        reg_rd(REG_IO_ST, v);  check("R4 io status", v, 32'hFFFF_FF0F);
        check("R4 pad_out mixed A/B", pad_out, (pa_out & 32'h30) | (pb_out & 32'hC0));
        check("R4 pad_oe mixed A/B", pad_oe, (pa_oe & 32'h30) | (pb_oe & 32'hC0));
        reg_wr(REG_SEL_A, 32'h0000_0040);
        reg_rd(REG_SEL_ST, v); check("R4 pick A clears", v, 32'h0000_0080);
        check("R4 pad_out after pick A", pad_out, (pa_out & 32'h70) | (pb_out & 32'h80));
        reg_wr(REG_IO_ON, '1);
        reg_wr(REG_SEL_A, '1);
        pa_out = '0; pa_oe = '0; pb_out = '0; pb_oe = '0;
    endtask

    task automatic t_pullup;
        logic [31:0] v;
        reg_wr(REG_PU_OFF, 32'h0000_0011);
        reg_rd(REG_PU_ST, v); check("R6 pull-up status disabled", v, 32'h0000_0011);
        check("R6 pad_pullup", pad_pullup, 32'hFFFF_FFEE);
        reg_wr(REG_PU_ON, 32'h0000_0001);
        reg_rd(REG_PU_ST, v); check("R6 pull-up re-enabled", v, 32'h0000_0010);
        check("R6 pad_pullup after enable", pad_pullup, 32'hFFFF_FFEF);
        reg_wr(REG_PU_ON, '1);
    endtask

    task automatic t_multidrive;
        reg_wr(REG_OE_ON, 32'h0000_000C);
        reg_wr(REG_MD_ON, 32'h0000_0008);
        reg_wr(REG_OUT_SET, 32'h0000_000C);
        #1;
        check("R7 high released oe", pad_oe & 32'hC, 32'h4);
        check("R7 high released out", pad_out & 32'hC, 32'h4);
        reg_wr(REG_OUT_CLR, 32'h0000_000C);
        #1;
        check("R7 low driven oe", pad_oe & 32'hC, 32'hC);
        check("R7 low driven out", pad_out & 32'hC, 32'h0);
        reg_wr(REG_MD_OFF, '1);
        reg_wr(REG_OE_OFF, '1);
    endtask

    task automatic t_sync;
        logic [31:0] v;
        @(negedge clk);
        pad_in = 32'h0F0F_1234;
        reg_peek(REG_PIN_ST, v); check("R8 level at 0 edges", v, 32'h0);
        @(negedge clk);
        reg_peek(REG_PIN_ST, v); check("R8 level at 1 edge", v, 32'h0);
        @(negedge clk);
        reg_peek(REG_PIN_ST, v); check("R8 level at 2 edges", v, 32'h0F0F_1234);
        @(negedge clk);
        pad_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_filter;
        logic [31:0] v;
        logic seen0, seen1;
        reg_wr(REG_FLT_ON, 32'h0000_0001);
        repeat (6) @(negedge clk);
        pad_in = 32'h1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            reg_peek(REG_PIN_ST, v);
            check($sformatf("R9 filtered level at %0d edges", k), v & 32'h1, (k == 4) ? 32'h1 : 32'h0);
        end
        pad_in = '0;
        repeat (6) @(negedge clk);
        pad_in = 32'h3;
        @(negedge clk);
        pad_in = '0;
        seen0 = 1'b0; seen1 = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            reg_peek(REG_PIN_ST, v);
            seen0 = seen0 | v[0];
            seen1 = seen1 | v[1];
        end
        check("R9 one-cycle pulse rejected", {31'h0, seen0}, 32'h0);
        check("R9 unfiltered pin saw pulse", {31'h0, seen1}, 32'h1);
        reg_wr(REG_FLT_OFF, '1);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        reg_wr(REG_OE_ST, '1);
        reg_wr(REG_MD_ST, '1);
        reg_wr(REG_PIN_ST, '1);
        reg_wr(REG_IO_ST, '0);
        reg_rd(REG_OE_ST, v); check("R10 drive status write ignored", v, 32'h0);
        reg_rd(REG_MD_ST, v); check("R10 multi-drive status write ignored", v, 32'h0);
        reg_rd(REG_IO_ST, v); check("R10 io status write ignored", v, 32'hFFFF_FFFF);
        check("R10 pads unchanged", pad_oe, 32'h0);
        reg_rd(REG_OE_ON, v); check("R10 write-only reads zero", v, 32'h0);
        reg_rd(5'h1F, v);     check("R10 unmapped reads zero", v, 32'h0);
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_output();
        t_io_drive();
        t_periph();
        t_pullup();
        t_multidrive();
        t_sync();
        t_filter();
        t_readonly();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule